// File: doc/BRIEF.md
# Cache Line Burst Bus Master

This block is the processor-side master of a 64-bit data bus for a cache whose lines hold four quadwords (32 bytes). The cache controller hands it one request at a time: a line fill, a standalone writeback of a modified line, or a fill that evicts a modified victim. Each request becomes a bus cycle that opens with a one-clock address strobe. The strobe carries the quadword address, a cache-intent flag, a page-cache-disable flag and a write flag. A read turns into a four-beat burst only when the block drove cache intent and the memory side returned cache-enable together with the first ready. Otherwise the read ends after that one beat as a single transfer.

Burst beats fill a line buffer in interleaved quadword order, starting from the quadword that was strobed. A one-cycle pulse reports the completed line. Writebacks are always four-beat bursts. Their data appears in the cycle after the strobe and moves to the next quadword in interleaved order on every ready. When a fill evicts a modified line, the writeback of that line is the very next bus cycle after the fill. If the memory side asks for the next address together with the first ready of a burst, the block may strobe one pending cycle early. The data phase of that cycle only starts once the current burst has taken its fourth ready.

Top module: `burst_line_master`

## Requirements
- R1: After reset the address strobe, write-data enable, line-done pulse and single-done pulse are low, and request-ready is high.
- R2: An accepted request is strobed for exactly one clock. During that clock the bus address, cache-intent and page-cache-disable outputs equal the request's values, and the write flag is low for reads.
- R3: A read strobed with cache intent that sees cache-enable high at its first ready takes four ready beats. The beat number k (0..3) lands in line-buffer quadword (start XOR k), where start is address bits [1:0], and quadword j sits at bits [64j+63:64j] of the line output. The line-done pulse rises in the cycle after the fourth ready, and cache intent stays high throughout the burst.
- R4: A read with cache-enable low at its first ready, or with cache intent low (whatever cache-enable says), ends after one ready. Single-done pulses in the next cycle with that beat's data, and no line-done pulse occurs.
- R5: Cache-enable is looked at only with the first ready of a cycle; its value on later beats has no effect.
- R6: Ready while no cycle is in its data phase, including the strobe clock of a non-pipelined cycle, is ignored.
- R7: After the last ready of a cycle with nothing pipelined behind it, at least one idle clock passes before the next strobe.
- R8: When next-address is high with the first ready of a burst and a request is pending, that request is strobed in the following clock while the burst goes on. At most one cycle is strobed ahead, and its data phase begins in the clock after the current burst's fourth ready.
- R9: A fill flagged with a victim is followed, as the next strobed cycle, by a writeback of the victim line at the victim address. A writeback strobes with write high, cache intent high and page-cache-disable low. It always takes four beats, regardless of cache-enable and of the request's cache-intent input.
- R10: Write data is enabled from the clock after the strobe until the last ready. It presents the quadword (start XOR k) of the line on beat k and holds steady through wait states.
- R11: Request-ready is low while any accepted cycle, including a queued victim writeback, is still waiting for its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this clock when high together with req_valid |
| req_wr | input | 1 | 1 = standalone writeback of req_line, 0 = line read |
| req_victim | input | 1 | On a read, also write back req_line at req_vaddr afterwards |
| req_cache | input | 1 | Cache intent for a read |
| req_pcd | input | 1 | Page-cache-disable for a read |
| req_addr | input | 29 | Quadword address of the cycle |
| req_vaddr | input | 29 | Quadword address of the victim line |
| req_line | input | 256 | Line data to write back |
| bus_ads | output | 1 | Address strobe, one clock per cycle |
| bus_addr | output | 29 | Quadword address |
| bus_cache | output | 1 | Cache intent |
| bus_pcd | output | 1 | Page-cache-disable |
| bus_wr | output | 1 | Write cycle |
| bus_rdy | input | 1 | Ready, one per data beat |
| bus_ken | input | 1 | Cache-enable, sampled with the first ready |
| bus_nxa | input | 1 | Next-address request, sampled with the first ready |
| bus_rdata | input | 64 | Read data |
| bus_wdata_oe | output | 1 | Write data valid |
| bus_wdata | output | 64 | Write data |
| fill_valid | output | 1 | One-clock pulse: line_out holds a complete line |
| fill_line | output | 256 | Filled line, quadword j at bits [64j+63:64j] |
| single_valid | output | 1 | One-clock pulse: single transfer completed |
| single_data | output | 64 | Data of the single transfer |

## Verification
The case that is hardest to reach from the ports is a clock holding three cycles at once. One burst is in its data phase, a second has already been strobed early, and a third is queued but must not be strobed. Getting there needs a new request accepted exactly on the clock of the first ready together with next-address, and a further request accepted one clock after the early strobe. The bench drives that sequence with exact timing. It then checks that the strobe stays low, that the early cycle takes its data only after the fourth beat, and that the idle clock appears before the queued cycle. A second directed sequence enters wait states in the middle of a victim writeback that follows a fill, to prove the write data holds.

// File: rtl/blm_pkg.sv
package blm_pkg;
  localparam int ADDR_W  = 32;
  localparam int QW_W    = 64;
  localparam int LINE_QW = 4;
  localparam int QIDX_W  = $clog2(LINE_QW);
  localparam int LINE_W  = QW_W * LINE_QW;
  localparam int OFF_W   = $clog2(QW_W / 8);
  localparam int BUS_AW  = ADDR_W - OFF_W;

  typedef struct packed {
    logic              wr;
    logic [BUS_AW-1:0] addr;
    logic              cache;
    logic              pcd;
    logic [LINE_W-1:0] line;
  } bus_cyc_t;

  // interleaved quadword order inside a line
  function automatic logic [QIDX_W-1:0] qw_slot(input logic [QIDX_W-1:0] start,
                                                input logic [QIDX_W-1:0] beat);
    return start ^ beat;
  endfunction

  // writes are always bursts, reads need both sides to agree
  function automatic logic wants_burst(input logic wr, input logic cache, input logic ken);
    return wr | (cache & ken);
  endfunction

  function automatic logic [QW_W-1:0] line_qw(input logic [LINE_W-1:0] line,
                                              input logic [QIDX_W-1:0] slot);
    return line[slot*QW_W +: QW_W];
  endfunction
endpackage

// File: rtl/blm_beat_track.sv
module blm_beat_track
  import blm_pkg::*;
#(
  parameter int BEATS = LINE_QW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              rdy,
  input  logic              cyc_wr,
  input  logic              cyc_cache,
  input  logic              ken,
  input  logic              nxa,
  input  logic [QIDX_W-1:0] start_slot,
  output logic              first,
  output logic              burst_now,
  output logic              last,
  output logic              nxa_seen,
  output logic [QIDX_W-1:0] slot
);
  localparam logic [QIDX_W-1:0] LAST_BEAT = QIDX_W'(BEATS - 1);

  logic [QIDX_W-1:0] beat_q;
  logic              burst_q;
  logic              nxa_q;

  assign first     = (beat_q == '0);
  assign burst_now = first ? wants_burst(cyc_wr, cyc_cache, ken) : burst_q;
  assign last      = rdy && (!burst_now || beat_q == LAST_BEAT);
  assign slot      = qw_slot(start_slot, beat_q);
  assign nxa_seen  = nxa_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q  <= '0;
      burst_q <= 1'b0;
      nxa_q   <= 1'b0;
    end else if (load) begin
      beat_q  <= '0;
      burst_q <= 1'b0;
      nxa_q   <= 1'b0;
    end else if (rdy) begin
      beat_q <= beat_q + 1'b1;
      if (first) begin
        burst_q <= burst_now;
        nxa_q   <= burst_now && nxa;
      end
    end
  end
endmodule

// File: rtl/blm_fill_buf.sv
module blm_fill_buf
  import blm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [QIDX_W-1:0] slot,
  input  logic [QW_W-1:0]   rdata,
  input  logic              last,
  input  logic              burst,
  output logic [LINE_W-1:0] fill_line,
  output logic              fill_valid,
  output logic              single_valid,
  output logic [QW_W-1:0]   single_data
);
  for (genvar g = 0; g < LINE_QW; g++) begin : g_qw
    logic [QW_W-1:0] qw_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  qw_q <= '0;
      else if (wen && slot == QIDX_W'(g))          qw_q <= rdata;
    end
    assign fill_line[g*QW_W +: QW_W] = qw_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_valid   <= 1'b0;
      single_valid <= 1'b0;
      single_data  <= '0;
    end else begin
      fill_valid   <= wen && last && burst;
      single_valid <= wen && last && !burst;
      if (wen && last && !burst) single_data <= rdata;
    end
  end
endmodule

// File: rtl/burst_line_master.sv
module burst_line_master
  import blm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic              req_victim,
  input  logic              req_cache,
  input  logic              req_pcd,
  input  logic [BUS_AW-1:0] req_addr,
  input  logic [BUS_AW-1:0] req_vaddr,
  input  logic [LINE_W-1:0] req_line,
  output logic              bus_ads,
  output logic [BUS_AW-1:0] bus_addr,
  output logic              bus_cache,
  output logic              bus_pcd,
  output logic              bus_wr,
  input  logic              bus_rdy,
  input  logic              bus_ken,
  input  logic              bus_nxa,
  input  logic [QW_W-1:0]   bus_rdata,
  output logic              bus_wdata_oe,
  output logic [QW_W-1:0]   bus_wdata,
  output logic              fill_valid,
  output logic [LINE_W-1:0] fill_line,
  output logic              single_valid,
  output logic [QW_W-1:0]   single_data
);
  // cycle slots: pending (not strobed), victim, next (strobed early), current (data phase)
  bus_cyc_t pend_q, vic_q, nxt_q, cur_q, aph_q, iss;
  logic     pend_v, vic_v, nxt_v, cur_v, gap_q;

  // named internal events
  logic have_pend, pipe_ok, rdy_cur, cyc_done, reload, load;
  logic first, burst_now, last, nxa_seen, accept;
  logic [QIDX_W-1:0] slot;
  logic rd_burst_mid;

  assign have_pend = pend_v || vic_v;
  assign iss       = pend_v ? pend_q : vic_q;
  assign pipe_ok   = cur_v && nxa_seen && !nxt_v;
  assign bus_ads   = have_pend && ((!cur_v && !gap_q) || pipe_ok);
  assign req_ready = !have_pend;
  assign accept    = req_valid && req_ready;

  assign rdy_cur  = bus_rdy && cur_v;
  assign cyc_done = cur_v && last;
  assign reload   = cyc_done && (nxt_v || bus_ads);
  assign load     = (bus_ads && !cur_v) || reload;
  assign rd_burst_mid = cur_v && !cur_q.wr && !first && burst_now;

  blm_beat_track #(.BEATS(LINE_QW)) u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .rdy        (rdy_cur),
    .cyc_wr     (cur_q.wr),
    .cyc_cache  (cur_q.cache),
    .ken        (bus_ken),
    .nxa        (bus_nxa),
    .start_slot (cur_q.addr[QIDX_W-1:0]),
    .first      (first),
    .burst_now  (burst_now),
    .last       (last),
    .nxa_seen   (nxa_seen),
    .slot       (slot)
  );

  blm_fill_buf u_fill (
    .clk          (clk),
    .rst_n        (rst_n),
    .wen          (rdy_cur && !cur_q.wr),
    .slot         (slot),
    .rdata        (bus_rdata),
    .last         (last),
    .burst        (burst_now),
    .fill_line    (fill_line),
    .fill_valid   (fill_valid),
    .single_valid (single_valid),
    .single_data  (single_data)
  );

  // address-phase outputs follow the strobe and hold until the next one
  assign bus_addr  = bus_ads ? iss.addr  : aph_q.addr;
  assign bus_cache = bus_ads ? iss.cache : aph_q.cache;
  assign bus_pcd   = bus_ads ? iss.pcd   : aph_q.pcd;
  assign bus_wr    = bus_ads ? iss.wr    : aph_q.wr;

  assign bus_wdata_oe = cur_v && cur_q.wr;
  assign bus_wdata    = bus_wdata_oe ? line_qw(cur_q.line, slot) : '0;

  // request intake
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      vic_v  <= 1'b0;
      pend_q <= '0;
      vic_q  <= '0;
    end else begin
      if (accept) begin
        pend_v       <= 1'b1;
        pend_q.wr    <= req_wr;
        pend_q.addr  <= req_addr;
        pend_q.cache <= req_wr ? 1'b1 : req_cache;
        pend_q.pcd   <= req_wr ? 1'b0 : req_pcd;
        pend_q.line  <= req_line;
        if (!req_wr && req_victim) begin
          vic_v       <= 1'b1;
          vic_q.wr    <= 1'b1;
          vic_q.addr  <= req_vaddr;
          vic_q.cache <= 1'b1;
          vic_q.pcd   <= 1'b0;
          vic_q.line  <= req_line;
        end
      end else if (bus_ads) begin
        if (pend_v) pend_v <= 1'b0;
        else        vic_v  <= 1'b0;
      end
    end
  end

  // strobe bookkeeping and data-phase ownership
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_v <= 1'b0;
      nxt_v <= 1'b0;
      gap_q <= 1'b0;
      cur_q <= '0;
      nxt_q <= '0;
      aph_q <= '0;
    end else begin
      gap_q <= cyc_done && !nxt_v && !bus_ads;
      if (bus_ads) aph_q <= iss;
      if (bus_ads && !cur_v) begin
        cur_v <= 1'b1;
        cur_q <= iss;
      end else if (cyc_done) begin
        if (nxt_v) begin
          cur_q <= nxt_q;
          nxt_v <= 1'b0;
        end else if (bus_ads) begin
          cur_q <= iss;
        end else begin
          cur_v <= 1'b0;
        end
      end else if (bus_ads) begin
        nxt_q <= iss;
        nxt_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/blm_checker.sv
module blm_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_ads,
  input logic bus_wr,
  input logic bus_cache,
  input logic bus_rdy,
  input logic fill_valid,
  input logic single_valid,
  input logic cur_v,
  input logic nxt_v,
  input logic cyc_done,
  input logic rd_burst_mid
);
  // R2: a strobe lasts one clock
  p_strobe_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads |=> !bus_ads);

  // R9: writebacks carry cache intent on the strobe
  p_wb_intent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ads && bus_wr) |-> bus_cache);

  // R3: intent stays up through a read burst until a pipelined strobe moves the address phase
  p_intent_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_burst_mid && !nxt_v && !bus_ads) |-> bus_cache);

  // R3: line completion follows a ready
  p_fill_after_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $past(bus_rdy));

  // R4: a cycle reports as a line or as a single, never both
  p_one_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !single_valid);

  // R7: idle clock after a cycle with nothing pipelined behind it
  p_idle_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !nxt_v && !bus_ads) |=> !bus_ads);

  // R8: only one cycle strobed ahead
  p_one_ahead_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ads && cur_v) |-> !nxt_v);
endmodule

bind burst_line_master blm_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_ads      (bus_ads),
  .bus_wr       (bus_wr),
  .bus_cache    (bus_cache),
  .bus_rdy      (bus_rdy),
  .fill_valid   (fill_valid),
  .single_valid (single_valid),
  .cur_v        (cur_v),
  .nxt_v        (nxt_v),
  .cyc_done     (cyc_done),
  .rd_burst_mid (rd_burst_mid)
);

// File: tb/burst_line_master_tb.sv
`timescale 1ns/1ps
module burst_line_master_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_wr, req_victim, req_cache, req_pcd;
  logic [28:0] req_addr, req_vaddr;
  logic [255:0] req_line;
  logic bus_rdy, bus_ken, bus_nxa;
  logic [63:0] bus_rdata;
  logic req_ready, bus_ads, bus_cache, bus_pcd, bus_wr, bus_wdata_oe;
  logic [28:0] bus_addr;
  logic [63:0] bus_wdata, single_data;
  logic fill_valid, single_valid;
  logic [255:0] fill_line;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  burst_line_master u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_victim(req_victim), .req_cache(req_cache), .req_pcd(req_pcd),
    .req_addr(req_addr), .req_vaddr(req_vaddr), .req_line(req_line),
    .bus_ads(bus_ads), .bus_addr(bus_addr), .bus_cache(bus_cache),
    .bus_pcd(bus_pcd), .bus_wr(bus_wr), .bus_rdy(bus_rdy), .bus_ken(bus_ken),
    .bus_nxa(bus_nxa), .bus_rdata(bus_rdata), .bus_wdata_oe(bus_wdata_oe),
    .bus_wdata(bus_wdata), .fill_valid(fill_valid), .fill_line(fill_line),
    .single_valid(single_valid), .single_data(single_data)
  );

  // fields: start qw[7:6], cache[5], pcd[4], ken at first ready[3], wait states[2:1], expect burst[0]
  localparam logic [7:0] VECS [6] = '{
    {2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1},
    {2'd1, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1},
    {2'd2, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1},
    {2'd2, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0},
    {2'd3, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0}
  };

  function automatic logic [63:0] pat(input int id, input int b);
    return {8'hC3, 8'(id), 40'h0, 8'(b)};
  endfunction

  // line expected from interleaved order: beat k goes to quadword start^k
  function automatic logic [255:0] exp_line(input int id, input logic [1:0] start);
    logic [255:0] l = '0;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] s = start ^ 2'(k);
      l[s*64 +: 64] = pat(id, k);
    end
    return l;
  endfunction

  task automatic ck(input string rq, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic offer(input logic [28:0] a, input logic wr, input logic vic,
                       input logic c, input logic p, input logic [28:0] va,
                       input logic [255:0] line);
    req_valid = 1'b1; req_wr = wr; req_victim = vic; req_cache = c; req_pcd = p;
    req_addr = a; req_vaddr = va; req_line = line;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_wr = 0; req_victim = 0; req_cache = 0; req_pcd = 0;
    req_addr = '0; req_vaddr = '0; req_line = '0;
    bus_rdy = 0; bus_ken = 0; bus_nxa = 0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    ck("R1 ads", 256'(bus_ads), 256'd0);
    ck("R1 ready", 256'(req_ready), 256'd1);
    ck("R1 fill_valid", 256'(fill_valid), 256'd0);
    ck("R1 single_valid", 256'(single_valid), 256'd0);
    ck("R1 wdata_oe", 256'(bus_wdata_oe), 256'd0);

    // vector table: reads with several intents, cache-enable answers and wait states
    for (int i = 0; i < 6; i++) begin
      logic [1:0] qw = VECS[i][7:6];
      logic c = VECS[i][5];
      logic p = VECS[i][4];
      logic k = VECS[i][3];
      int   w = int'(VECS[i][2:1]);
      logic eb = VECS[i][0];
      logic [28:0] a = {27'(27'h12340 + i), qw};
      int nb = eb ? 4 : 1;
      offer(a, 1'b0, 1'b0, c, p, '0, '0);
      step();
      req_valid = 1'b0;
      ck("R2 strobe", 256'(bus_ads), 256'd1);
      ck("R2 addr", 256'(bus_addr), 256'(a));
      ck("R2 intent", 256'(bus_cache), 256'(c));
      ck("R2 pcd", 256'(bus_pcd), 256'(p));
      ck("R2 write flag", 256'(bus_wr), 256'd0);
      step();
      for (int b = 0; b < nb; b++) begin
        for (int j = 0; j < w; j++) begin bus_rdy = 1'b0; step(); end
        bus_rdy = 1'b1;
        bus_ken = (b == 0) ? k : !k;   // R5: later cache-enable values flipped
        bus_rdata = pat(i, b);
        step();
      end
      bus_rdy = 1'b0;
      if (eb) begin
        ck("R3 fill_valid", 256'(fill_valid), 256'd1);
        ck("R3 line order", fill_line, exp_line(i, qw));
        ck("R5 no single", 256'(single_valid), 256'd0);
      end else begin
        ck("R4 single_valid", 256'(single_valid), 256'd1);
        ck("R4 single data", 256'(single_data), 256'(pat(i, 0)));
        ck("R4 no fill", 256'(fill_valid), 256'd0);
      end
      step(); step();
    end

    // R6: ready while idle and during the strobe clock is ignored
    bus_rdy = 1'b1; bus_ken = 1'b1; bus_rdata = 64'hDEAD;
    step(); step();
    ck("R6 idle single", 256'(single_valid), 256'd0);
    ck("R6 idle fill", 256'(fill_valid), 256'd0);
    offer({27'h2000, 2'd0}, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
    step();
    req_valid = 1'b0;
    step();
    for (int b = 0; b < 4; b++) begin
      bus_rdata = pat(9, b);
      if (b == 3) ck("R6 fill not early", 256'(fill_valid), 256'd0);
      step();
    end
    bus_rdy = 1'b0;
    ck("R6 fill after four", 256'(fill_valid), 256'd1);
    ck("R6 line", fill_line, exp_line(9, 2'd0));
    step(); step();

    // R8: next-address pipelining, one cycle ahead, plus R7 gap
    offer({27'h3000, 2'd0}, 1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
    step();
    req_valid = 1'b0;
    ck("R2 strobe A", 256'(bus_ads), 256'd1);
    step();
    ck("R11 ready for B", 256'(req_ready), 256'd1);
    offer({27'h3100, 2'd1}, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    bus_rdy = 1'b1; bus_nxa = 1'b1; bus_ken = 1'b1; bus_rdata = pat(20, 0);
    step();
    req_valid = 1'b0; bus_nxa = 1'b0;
    ck("R8 early strobe", 256'(bus_ads), 256'd1);
    ck("R8 early addr", 256'(bus_addr), 256'({27'h3100, 2'd1}));
    bus_rdata = pat(20, 1);
    step();
    ck("R8 strobe once", 256'(bus_ads), 256'd0);
    ck("R11 ready for C", 256'(req_ready), 256'd1);
    offer({27'h3200, 2'd2}, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    bus_rdata = pat(20, 2);
    step();
    req_valid = 1'b0;
    ck("R8 only one ahead", 256'(bus_ads), 256'd0);
    bus_rdata = pat(20, 3);
    step();
    ck("R8 A completes", 256'(fill_valid), 256'd1);
    ck("R8 A line", fill_line, exp_line(20, 2'd0));
    ck("R8 no strobe in B data", 256'(bus_ads), 256'd0);
    bus_rdata = pat(21, 0);
    step();
    bus_rdy = 1'b0;
    ck("R4 B single", 256'(single_valid), 256'd1);
    ck("R4 B data", 256'(single_data), 256'(pat(21, 0)));
    ck("R7 idle clock", 256'(bus_ads), 256'd0);
    step();
    ck("R7 C strobe", 256'(bus_ads), 256'd1);
    ck("R7 C addr", 256'(bus_addr), 256'({27'h3200, 2'd2}));
    step();
    bus_rdy = 1'b1; bus_ken = 1'b0; bus_rdata = pat(22, 0);
    step();
    bus_rdy = 1'b0;
    ck("R4 C single", 256'(single_valid), 256'd1);
    step(); step();

    // R9/R10/R11: fill with a victim, then the writeback with a wait state
    begin
      logic [255:0] vl = {pat(7, 3), pat(7, 2), pat(7, 1), pat(7, 0)};
      offer({27'h4000, 2'd1}, 1'b0, 1'b1, 1'b1, 1'b0, {27'h5000, 2'd2}, vl);
      step();
      req_valid = 1'b0;
      ck("R11 busy with victim", 256'(req_ready), 256'd0);
      step();
      bus_ken = 1'b1; bus_rdy = 1'b1;
      for (int b = 0; b < 4; b++) begin bus_rdata = pat(8, b); step(); end
      bus_rdy = 1'b0; bus_ken = 1'b0;
      ck("R9 fill first", 256'(fill_valid), 256'd1);
      ck("R9 fill line", fill_line, exp_line(8, 2'd1));
      ck("R7 gap before writeback", 256'(bus_ads), 256'd0);
      ck("R11 still busy", 256'(req_ready), 256'd0);
      step();
      ck("R9 wb strobe", 256'(bus_ads), 256'd1);
      ck("R9 wb addr", 256'(bus_addr), 256'({27'h5000, 2'd2}));
      ck("R9 wb write", 256'(bus_wr), 256'd1);
      ck("R9 wb intent", 256'(bus_cache), 256'd1);
      ck("R9 wb pcd", 256'(bus_pcd), 256'd0);
      ck("R10 no data on strobe", 256'(bus_wdata_oe), 256'd0);
      step();
      ck("R10 data enabled", 256'(bus_wdata_oe), 256'd1);
      ck("R10 beat0", 256'(bus_wdata), 256'(pat(7, 2)));
      ck("R11 free again", 256'(req_ready), 256'd1);
      step();
      ck("R10 held in wait", 256'(bus_wdata), 256'(pat(7, 2)));
      bus_rdy = 1'b1;
      step();
      ck("R10 beat1", 256'(bus_wdata), 256'(pat(7, 3)));
      step();
      ck("R10 beat2", 256'(bus_wdata), 256'(pat(7, 0)));
      step();
      ck("R10 beat3", 256'(bus_wdata), 256'(pat(7, 1)));
      step();
      bus_rdy = 1'b0;
      ck("R9 four beats only", 256'(bus_wdata_oe), 256'd0);
      ck("R9 wb no fill", 256'(fill_valid), 256'd0);
    end
    step();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule